// File: doc/BRIEF.md
# Chainable Four-Channel Countdown Timer Group

This block holds four countdown timers that share one prescaled time base. Each timer reloads itself from a programmable base value every time it runs out, so once started it raises an interrupt at a fixed period until software stops it. One group control word selects the shared divide ratio. The same word can also join neighbouring timers, so that the lower timer of a pair supplies the carries for the upper one and the pair acts as one long counter.

Software reaches the block through a plain word-wide register port: a write strobe, an address and write data, with read data registered one cycle after the address. Each timer has a remaining-count register that software reads to see elapsed progress. Bit 31 of that register is a flag that changes state each time the timer expires. Each timer also has two plain storage words that its interrupt routing logic uses elsewhere. The four interrupt outputs are single-cycle pulses.

Top module: `tmr_group`

## Requirements
- R1: After a synchronous reset every timer is stopped, its count register reads 0 and its base register reads 0x8000_0000. The group word reads 0 (divide by 8) and all interrupt outputs are low.
- R2: Timer k occupies a 64-byte window at byte address k*0x40. Inside it, offset 0x00 is the count (read only), 0x10 the base, 0x20 and 0x30 two storage words. The group word is at 0x100. An address with nonzero bits [3:0] selects nothing. Read data appears on the clock edge after the address.
- R3: Base bit 31 is a stop flag and bits 30:0 are the count. Writing the base with bit 31 clear loads the count from bits 30:0, and the timer starts counting down.
- R4: Writing the base with bit 31 set to a stopped timer loads its count from bits 30:0. Writing it to a running timer clears the whole count register to 0. A stopped timer's count does not change.
- R5: Group bits 9:8 choose the shared divider: 00 gives /8, 01 gives /16, 10 gives /32 and 11 gives /64.
- R6: A running timer that sees a prescaler tick while its count is 0 reloads from its base and pulses its interrupt for exactly one clock. The interrupt period is therefore divider*(base+1) clocks.
- R7: Bit 31 of the count register inverts on every expiry of that timer.
- R8: Group bits 0, 1 and 2 chain timer pairs 0/1, 1/2 and 2/3. The upper timer then counts only on the lower timer's expiries and keeps its own interrupt. The lower timer raises no interrupt. The upper timer's period becomes divider*(base_low+1)*(base_high+1).
- R9: Group bits 24, 25 and 26 set rollover for the same pairs. A chained lower timer with rollover set reloads 0x7FFF_FFFF instead of its base when it expires.
- R10: Writes to a count register have no effect.
- R11: The two storage words of each timer read back what was last written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 9 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data for addr_i |
| irq_o | output | 4 | Per-timer expiry pulse |

## Verification
The bench measures the spacing between interrupt pulses for several divider and base settings. A prescaler that is off by one, or a reload that skips the zero state, would show up as a wrong period. It stops a timer both while it runs and while it is already stopped, so that the different effects of the same write on the count are separated, and it writes to the read-only count register to make sure the value stays. In the chained tests, a lower timer that still raised interrupts, or an upper timer that counted prescaler ticks directly, would produce the wrong pulse count or the wrong spacing. A rollover bit that was ignored would leave the lower timer's count small after its first expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // address layout
  localparam int WIN_SHIFT = 6;      // 64-byte window per timer
  localparam int REG_SHIFT = 4;      // 16-byte stride between registers
  localparam int GRP_ADDR  = 'h100;  // group control word
  // group control fields
  localparam int CAS_LSB  = 0;
  localparam int DIV_LSB  = 8;
  localparam int ROLL_LSB = 24;
  localparam int BASE_DIV_LOG2 = 3;  // divider 8 at select 0

  typedef enum logic [1:0] {
    RK_CUR  = 2'd0,
    RK_BASE = 2'd1,
    RK_VEC  = 2'd2,
    RK_DST  = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int SELW = 2,
  parameter int MINL = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SELW-1:0] sel_i,
  output logic            tick_o
);
  localparam int CW = MINL + (1 << SELW) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = CW'((1 << (MINL + int'(sel_i))) - 1);
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R5: ticks never come back to back, because every divider is at least 8
  a_r5_tick_gap: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          low_i,
  input  logic          roll_i,
  output logic [DW-1:0] base_o,
  output logic [DW-1:0] cur_o,
  output logic          carry_o,
  output logic          irq_o
);
  localparam int CNTW = DW - 1;

  logic [DW-1:0]   base_q;
  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] reload;
  logic            tog_q;
  logic            stop;

  assign stop    = base_q[DW-1];
  assign carry_o = tick_i && !stop && (cnt_q == '0);
  assign reload  = (low_i && roll_i) ? {CNTW{1'b1}} : base_q[CNTW-1:0];
  assign base_o  = base_q;
  assign cur_o   = {tog_q, cnt_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= {1'b1, {CNTW{1'b0}}};
      cnt_q  <= '0;
      tog_q  <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (wr_i) begin
        base_q <= wdata_i;
        if (!wdata_i[DW-1] || stop) begin
          cnt_q <= wdata_i[CNTW-1:0];
        end else begin
          cnt_q <= '0;
          tog_q <= 1'b0;
        end
      end else if (carry_o) begin
        cnt_q <= reload;
        tog_q <= ~tog_q;
        irq_o <= !low_i;
      end else if (tick_i && !stop) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R4: a stopped timer with no write holds its count
  a_r4_stop_hold: assert property (@(posedge clk) disable iff (rst)
    (stop && !wr_i) |=> $stable(cnt_q));
  // R6: the interrupt lasts one clock
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
  // R7: the flag flips with every interrupt
  a_r7_flag_flip: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (tog_q != $past(tog_q)));
  // R8: a chained lower timer never raises an interrupt
  a_r8_low_quiet: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> !$past(low_i));
endmodule

// File: rtl/tmr_group.sv
module tmr_group #(
  parameter int NT = 4,
  parameter int DW = 32,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [NT-1:0] irq_o
);
  import tmr_pkg::*;

  localparam int SW = $clog2(NT);
  localparam int NP = NT - 1;

  logic          grp_hit, tmr_hit;
  logic [SW-1:0] sel;
  reg_kind_e     kind;
  logic [1:0]    div_q;
  logic [NP-1:0] cas_q, roll_q;
  logic [DW-1:0] grp_rd;
  logic          ptick;
  logic [NT-1:0] carry;
  logic [DW-1:0] cur_w  [NT];
  logic [DW-1:0] base_w [NT];
  logic [DW-1:0] vec_q  [NT];
  logic [DW-1:0] dst_q  [NT];

  assign grp_hit = (addr_i == AW'(GRP_ADDR));
  assign tmr_hit = (addr_i[AW-1:WIN_SHIFT+SW] == '0) && (addr_i[REG_SHIFT-1:0] == '0);
  assign sel     = addr_i[WIN_SHIFT +: SW];
  assign kind    = reg_kind_e'(addr_i[REG_SHIFT +: 2]);

  always_comb begin
    grp_rd = '0;
    grp_rd[DIV_LSB +: 2]   = div_q;
    grp_rd[CAS_LSB +: NP]  = cas_q;
    grp_rd[ROLL_LSB +: NP] = roll_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      cas_q  <= '0;
      roll_q <= '0;
    end else if (we_i && grp_hit) begin
      div_q  <= wdata_i[DIV_LSB +: 2];
      cas_q  <= wdata_i[CAS_LSB +: NP];
      roll_q <= wdata_i[ROLL_LSB +: NP];
    end
  end

  tmr_prescale #(.SELW(2), .MINL(BASE_DIV_LOG2)) u_pre (
    .clk(clk), .rst(rst), .sel_i(div_q), .tick_o(ptick)
  );

  for (genvar k = 0; k < NT; k++) begin : g_ch
    logic tk, lo, ro, wr_base;
    if (k == 0) begin : g_first
      assign tk = ptick;
    end else begin : g_rest
      assign tk = cas_q[k-1] ? carry[k-1] : ptick;
    end
    if (k == NT-1) begin : g_last
      assign lo = 1'b0;
      assign ro = 1'b0;
    end else begin : g_mid
      assign lo = cas_q[k];
      assign ro = roll_q[k];
    end
    assign wr_base = we_i && tmr_hit && (sel == SW'(k)) && (kind == RK_BASE);

    tmr_chan #(.DW(DW)) u_ch (
      .clk(clk), .rst(rst), .tick_i(tk), .wr_i(wr_base), .wdata_i(wdata_i),
      .low_i(lo), .roll_i(ro), .base_o(base_w[k]), .cur_o(cur_w[k]),
      .carry_o(carry[k]), .irq_o(irq_o[k])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        vec_q[k] <= '0;
        dst_q[k] <= '0;
      end else if (we_i && tmr_hit && (sel == SW'(k))) begin
        if (kind == RK_VEC) vec_q[k] <= wdata_i;
        if (kind == RK_DST) dst_q[k] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= '0;
      if (grp_hit) begin
        rdata_o <= grp_rd;
      end else if (tmr_hit) begin
        unique case (kind)
          RK_CUR:  rdata_o <= cur_w[sel];
          RK_BASE: rdata_o <= base_w[sel];
          RK_VEC:  rdata_o <= vec_q[sel];
          RK_DST:  rdata_o <= dst_q[sel];
        endcase
      end
    end
  end

  // R1: interrupts stay low in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (irq_o == '0));
endmodule

// File: tb/sim_tmr_group.sv
module sim_tmr_group;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we_i = 1'b0;
  logic [8:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  irq_o;

  int n_chk = 0;
  int n_bad = 0;
  int pulses [4] = '{0, 0, 0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_group u0 (.clk(clk), .rst(rst), .we_i(we_i), .addr_i(addr_i),
                .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o));

  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) if (!rst && irq_o[k]) pulses[k]++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    addr_i = a;
    @(negedge clk);
    d = rdata_o;
  endtask

  function automatic logic [8:0] ta(input int k, input int off);
    return 9'(k * 'h40 + off);
  endfunction

  task automatic stop_all();
    for (int k = 0; k < 4; k++) wr(ta(k, 'h10), 32'h8000_0000);
    wr(9'h100, 32'h0);
  endtask

  // waits for a pulse on irq k; returns the clocks waited
  task automatic wait_pulse(input int k, input int limit, output int cyc, output bit hit);
    hit = 1'b0;
    cyc = 0;
    while (!hit && cyc < limit) begin
      @(negedge clk);
      cyc++;
      if (irq_o[k]) hit = 1'b1;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(irq_o == 4'h0, "R1 irq after reset", {28'h0, irq_o}, 32'h0);
    for (int k = 0; k < 4; k++) begin
      rd(ta(k, 'h00), d);
      check(d == 32'h0, "R1 count after reset", d, 32'h0);
      rd(ta(k, 'h10), d);
      check(d == 32'h8000_0000, "R1 base after reset", d, 32'h8000_0000);
    end
    rd(9'h100, d);
    check(d == 32'h0, "R1 group word after reset", d, 32'h0);
  endtask

  task automatic t_storage();
    logic [31:0] d;
    wr(ta(2, 'h20), 32'hA5A5_0003);
    wr(ta(1, 'h30), 32'h0000_0002);
    rd(ta(2, 'h20), d);
    check(d == 32'hA5A5_0003, "R11 storage word 0x20", d, 32'hA5A5_0003);
    rd(ta(1, 'h30), d);
    check(d == 32'h0000_0002, "R11 storage word 0x30", d, 32'h2);
    rd(ta(3, 'h10), d);
    check(d == 32'h8000_0000, "R2 neighbour base untouched", d, 32'h8000_0000);
    wr(ta(2, 'h24), 32'h1234_5678);
    rd(ta(2, 'h20), d);
    check(d == 32'hA5A5_0003, "R2 unaligned address ignored", d, 32'hA5A5_0003);
    wr(9'h100, 32'h0700_0307);
    rd(9'h100, d);
    check(d == 32'h0700_0307, "R2 group word readback", d, 32'h0700_0307);
    wr(9'h100, 32'h0);
  endtask

  task automatic t_load_stop();
    logic [31:0] d;
    wr(ta(1, 'h10), 32'h8000_0007);
    rd(ta(1, 'h00), d);
    check(d == 32'h7, "R4 stopped base write loads count", d, 32'h7);
    wr(ta(1, 'h00), 32'h0000_0055);
    rd(ta(1, 'h00), d);
    check(d == 32'h7, "R10 count register write ignored", d, 32'h7);
    wr(ta(1, 'h10), 32'h0000_0064);
    rd(ta(1, 'h00), d);
    check(d == 32'h64 || d == 32'h63, "R3 start loads base", d, 32'h64);
    repeat (40) @(negedge clk);
    rd(ta(1, 'h00), d);
    check(d < 32'h63 && d > 32'h58, "R3 running timer counts down", d, 32'h5E);
    wr(ta(1, 'h10), 32'h8000_0064);
    rd(ta(1, 'h00), d);
    check(d == 32'h0, "R4 stop while running clears count", d, 32'h0);
    repeat (30) @(negedge clk);
    rd(ta(1, 'h00), d);
    check(d == 32'h0, "R4 stopped count holds", d, 32'h0);
  endtask

  task automatic t_period(input logic [1:0] dsel, input int base, input int expct);
    int c;
    bit h;
    wr(9'h100, {22'h0, dsel, 8'h0});
    wr(ta(3, 'h10), 32'(base));
    wait_pulse(3, 2000, c, h);
    check(h, "R6 first expiry seen", 32'(h), 32'h1);
    @(negedge clk);
    check(irq_o[3] == 1'b0, "R6 pulse lasts one clock", {31'h0, irq_o[3]}, 32'h0);
    wait_pulse(3, 2000, c, h);
    check(c == expct - 1, "R5 R6 interrupt period", 32'(c + 1), 32'(expct));
    stop_all();
  endtask

  task automatic t_toggle();
    logic [31:0] a, b;
    int c;
    bit h;
    wr(ta(0, 'h10), 32'd20);
    wait_pulse(0, 2000, c, h);
    rd(ta(0, 'h00), a);
    wait_pulse(0, 2000, c, h);
    rd(ta(0, 'h00), b);
    check(a[31] != b[31], "R7 flag flips each expiry", b, {~a[31], a[30:0]});
    check(b[30:0] <= 31'd20, "R6 reload from base", b & 32'h7FFF_FFFF, 32'd20);
    stop_all();
  endtask

  task automatic t_cascade();
    int c, p0;
    bit h;
    wr(9'h100, 32'h0000_0001);
    wr(ta(1, 'h10), 32'd2);
    wr(ta(0, 'h10), 32'd1);
    p0 = pulses[0];
    wait_pulse(1, 3000, c, h);
    wait_pulse(1, 3000, c, h);
    check(h && c == 48, "R8 chained upper period", 32'(c), 32'd48);
    check(pulses[0] == p0, "R8 chained lower timer silent", 32'(pulses[0] - p0), 32'h0);
    stop_all();
  endtask

  task automatic t_roll();
    logic [31:0] d;
    int p2;
    wr(9'h100, 32'h0400_0004);
    wr(ta(3, 'h10), 32'd5);
    p2 = pulses[2];
    wr(ta(2, 'h10), 32'd2);
    repeat (40) @(negedge clk);
    rd(ta(2, 'h00), d);
    check(d[30:0] >= 31'h7FFF_FF00, "R9 rollover reload", d & 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    rd(ta(3, 'h00), d);
    check(d == 32'd4, "R8 upper counts lower expiry", d, 32'd4);
    check(pulses[2] == p2, "R9 lower timer silent", 32'(pulses[2] - p2), 32'h0);
    stop_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_storage();
    t_load_stop();
    t_period(2'd0, 3, 32);
    t_period(2'd1, 2, 48);
    t_period(2'd3, 0, 64);
    t_period(2'd2, 1, 64);
    t_toggle();
    t_cascade();
    t_roll();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog run did not finish", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule